// File: doc/BRIEF.md
# Audio Controller Global Control and Status Unit

This unit holds the registers that three audio DMA channels share: a six-bit global control register, an eighteen-bit global status register and a one-bit semaphore that guards access to the codec. Software reaches them over a simple 32-bit register bus. Each access carries a byte offset and a size code.

The control register raises one-cycle warm-reset and cold-reset pulses. A write that requests either reset does not update the stored control value. The status word combines three kinds of bit:

- read/write bits;
- sticky event bits, set by hardware and cleared by writing a one;
- read-only bits, which include the live interrupt line of each channel and a codec-ready bit fixed at one.

The semaphore gives one owner to a codec access. A byte read returns the current value and then sets it. The codec-access-done pulse releases it.

A combined interrupt output is the OR of the three channel interrupt inputs. Read data is registered: it appears together with a valid flag one cycle after the read is presented.

Top module: `glob_ctl_unit`

## Requirements
- R1: After a synchronous reset, the control register, the stored status bits and the semaphore are zero, and `irq_out`, `warm_rst_pulse`, `cold_rst_pulse` and `bus_rvalid` are low.
- R2: A word write (size code 2) to offset 0x2C with bits 2 and 1 both clear stores bits 5:0. A word read of 0x2C returns them zero-extended.
- R3: A word write to 0x2C with bit 2 set drives `warm_rst_pulse` high for exactly the next cycle. With bit 1 set it drives `cold_rst_pulse` the same way. Such a write leaves the stored control value unchanged.
- R4: A word write to offset 0x30 stores bits 17 and 16 as read/write bits. Writes to read-only status positions have no effect on the value read back.
- R5: Sticky status bits 0, 10, 11 and 15 are set by `sticky_evt[0]`, `[1]`, `[2]` and `[3]` respectively, and are cleared by a word write of one to that bit position. Writing zero keeps them. If an event and a clear fall in the same cycle, the event wins.
- R6: A word read of 0x30 returns bits 5, 6 and 7 equal to `chan_irq[0]`, `[1]` and `[2]` in the read cycle. Bit 8 reads one. Bits 1 to 4, 9, 12 to 14 and 31:18 read zero.
- R7: A byte read (size code 0) of offset 0x34 returns the semaphore in bit 0, with all other bits zero, and leaves the semaphore set to one.
- R8: `codec_done` clears the semaphore. When it coincides with a semaphore read, the read returns the old value and the semaphore ends at zero.
- R9: `irq_out` equals the OR of `chan_irq`, one cycle later.
- R10: A read of any other offset, or of a mapped offset with the wrong size, returns all ones. Writes there, including any write to 0x34, change no state and raise no pulse.
- R11: `bus_rvalid` is high in the cycle after a read is presented, and low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word |
| bus_addr | input | ADDR_W (6) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| chan_irq | input | NCHAN (3) | Interrupt lines of the input, output and microphone channels |
| sticky_evt | input | 4 | Hardware events for the sticky status bits |
| codec_done | input | 1 | Codec access completed, releases the semaphore |
| irq_out | output | 1 | Combined interrupt |
| warm_rst_pulse | output | 1 | One-cycle warm-reset request |
| cold_rst_pulse | output | 1 | One-cycle cold-reset request |

## Verification
Two pairs of actions can land in the same cycle:

- A semaphore byte read and a `codec_done` pulse. The bench takes the semaphore, then issues the read with `codec_done` high in that very cycle. It expects the old value (one) on the bus, and zero from the following read.
- A sticky event and the write that clears it. The bench issues a status write clearing bit 15 while `sticky_evt[3]` is high, and expects bit 15 still set on readback.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int CTRL_W   = 6;
  localparam int STAT_W   = 18;
  localparam int NSTICKY  = 4;
  localparam int WARM_BIT = 2;
  localparam int COLD_BIT = 1;
  localparam int IRQ_BASE = 5;
  localparam int RDY_BIT  = 8;
  localparam int RW_LO    = 16;
  localparam int RW_W     = 2;

  localparam logic [7:0] OFF_CTRL = 8'h2C;
  localparam logic [7:0] OFF_STAT = 8'h30;
  localparam logic [7:0] OFF_SEM  = 8'h34;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // status position of each sticky event bit
  function automatic int sticky_pos(input int k);
    case (k)
      0:       return 0;
      1:       return 10;
      2:       return 11;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/gcs_ctrl_reg.sv
module gcs_ctrl_reg
  import gcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              warm_pulse,
  output logic              cold_pulse
);
  logic rst_req;
  assign rst_req = wdata[WARM_BIT] | wdata[COLD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      warm_pulse <= 1'b0;
      cold_pulse <= 1'b0;
    end else begin
      warm_pulse <= wr_en & wdata[WARM_BIT];
      cold_pulse <= wr_en & wdata[COLD_BIT];
      if (wr_en && !rst_req) ctrl_q <= wdata;
    end
  end

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rst_req) |=> $stable(ctrl_q)); // R3
  AST_WARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    warm_pulse |-> $past(wr_en && wdata[WARM_BIT])); // R3
  AST_COLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cold_pulse |-> $past(wr_en && wdata[COLD_BIT])); // R3
endmodule

// File: rtl/gcs_status_reg.sv
module gcs_status_reg
  import gcs_pkg::*;
#(
  parameter int NCHAN = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [STAT_W-1:0]  wdata,
  input  logic [NSTICKY-1:0] evt,
  input  logic [NCHAN-1:0]   chan_irq,
  output logic [STAT_W-1:0]  view
);
  logic [RW_W-1:0]    rw_q;
  logic [NSTICKY-1:0] sticky_q;
  logic               unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst)        rw_q <= '0;
    else if (wr_en) rw_q <= wdata[RW_LO +: RW_W];
  end

  for (genvar k = 0; k < NSTICKY; k++) begin : g_sticky
    localparam int P = sticky_pos(k);
    always_ff @(posedge clk) begin
      if (rst)                        sticky_q[k] <= 1'b0;
      else if (evt[k])                sticky_q[k] <= 1'b1;
      else if (wr_en && wdata[P])     sticky_q[k] <= 1'b0;
    end
    AST_STICKY_CLR: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wdata[P] && !evt[k]) |=> !sticky_q[k]); // R5
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
      evt[k] |=> sticky_q[k]); // R5
  end

  always_comb begin
    view = '0;
    view[RDY_BIT] = 1'b1;
    view[IRQ_BASE +: NCHAN] = chan_irq;
    view[RW_LO +: RW_W] = rw_q;
    for (int k = 0; k < NSTICKY; k++) view[sticky_pos(k)] = sticky_q[k];
  end
endmodule

// File: rtl/gcs_semaphore.sv
module gcs_semaphore (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic release_i,
  output logic sem_q
);
  always_ff @(posedge clk) begin
    if (rst)            sem_q <= 1'b0;
    else if (release_i) sem_q <= 1'b0;
    else if (take)      sem_q <= 1'b1;
  end

  AST_SEM_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (take && !release_i) |=> sem_q); // R7
  AST_SEM_FREED: assert property (@(posedge clk) disable iff (rst)
    release_i |=> !sem_q); // R8
endmodule

// File: rtl/glob_ctl_unit.sv
module glob_ctl_unit
  import gcs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int NCHAN  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic [NCHAN-1:0]   chan_irq,
  input  logic [NSTICKY-1:0] sticky_evt,
  input  logic               codec_done,
  output logic               irq_out,
  output logic               warm_rst_pulse,
  output logic               cold_rst_pulse
);
  logic hit_ctrl, hit_stat, hit_sem, rd, rd_miss;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_view;
  logic              sem_q;
  logic              unused_wbits;

  assign hit_ctrl = bus_sel && bus_addr == ADDR_W'(OFF_CTRL) && bus_size == SZ_WORD;
  assign hit_stat = bus_sel && bus_addr == ADDR_W'(OFF_STAT) && bus_size == SZ_WORD;
  assign hit_sem  = bus_sel && bus_addr == ADDR_W'(OFF_SEM)  && bus_size == SZ_BYTE;
  assign rd       = bus_sel && !bus_wr;
  assign rd_miss  = rd && !hit_ctrl && !hit_stat && !hit_sem;
  assign unused_wbits = ^bus_wdata[DATA_W-1:STAT_W];

  gcs_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(hit_ctrl && bus_wr),
    .wdata(bus_wdata[CTRL_W-1:0]),
    .ctrl_q(ctrl_q),
    .warm_pulse(warm_rst_pulse),
    .cold_pulse(cold_rst_pulse)
  );

  gcs_status_reg #(.NCHAN(NCHAN)) u_stat (
    .clk(clk), .rst(rst),
    .wr_en(hit_stat && bus_wr),
    .wdata(bus_wdata[STAT_W-1:0]),
    .evt(sticky_evt),
    .chan_irq(chan_irq),
    .view(stat_view)
  );

  gcs_semaphore u_sem (
    .clk(clk), .rst(rst),
    .take(hit_sem && !bus_wr),
    .release_i(codec_done),
    .sem_q(sem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_out    <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      irq_out    <= |chan_irq;
      if (rd) begin
        if (hit_ctrl)      bus_rdata <= DATA_W'(ctrl_q);
        else if (hit_stat) bus_rdata <= DATA_W'(stat_view);
        else if (hit_sem)  bus_rdata <= DATA_W'(sem_q);
        else               bus_rdata <= '1;
      end
    end
  end

  AST_RDY_ONE: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(hit_stat && !bus_wr)) |-> bus_rdata[RDY_BIT]); // R6
  AST_MISS_ONES: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(rd_miss)) |-> (bus_rdata == '1)); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (|chan_irq) |=> irq_out); // R9
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    !(|chan_irq) |=> !irq_out); // R9
  AST_RVALID: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid); // R11
endmodule

// File: tb/glob_ctl_unit_test.sv
`timescale 1ns/1ps
module glob_ctl_unit_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, bus_sel = 1'b0, bus_wr = 1'b0, codec_done = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, irq_out, warm_rst_pulse, cold_rst_pulse;
  logic [2:0] chan_irq = '0;
  logic [3:0] sticky_evt = '0;

  glob_ctl_unit uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .chan_irq(chan_irq), .sticky_evt(sticky_evt),
    .codec_done(codec_done), .irq_out(irq_out),
    .warm_rst_pulse(warm_rst_pulse), .cold_rst_pulse(cold_rst_pulse)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access cycle; outputs are sampled at the following negedge
  task automatic access(input logic wr, input logic [1:0] sz, input logic [5:0] a,
                        input logic [31:0] wd, input logic [2:0] irq,
                        input logic [3:0] evt, input logic done);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
    chan_irq = irq; sticky_evt = evt; codec_done = done;
    @(negedge clk);
    bus_sel = 1'b0; sticky_evt = '0; codec_done = 1'b0;
  endtask

  task automatic idle(input logic [3:0] evt, input logic done);
    @(negedge clk);
    sticky_evt = evt; codec_done = done;
    @(negedge clk);
    sticky_evt = '0; codec_done = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [5:0]  addr;
    logic [31:0] wd;
    logic [2:0]  irq;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 6'h2C, 32'h0,        3'b000, 32'h0,        4'd1},  // R1 control zero
    '{1'b0, 2'd2, 6'h30, 32'h0,        3'b000, 32'h100,      4'd1},  // R1 status only ready bit
    '{1'b1, 2'd2, 6'h2C, 32'h39,       3'b000, 32'h0,        4'd2},
    '{1'b0, 2'd2, 6'h2C, 32'h0,        3'b000, 32'h39,       4'd2},  // R2
    '{1'b1, 2'd2, 6'h2C, 32'hFFFFFFC8, 3'b000, 32'h0,        4'd2},
    '{1'b0, 2'd2, 6'h2C, 32'h0,        3'b000, 32'h08,       4'd2},  // R2 upper bits dropped
    '{1'b1, 2'd2, 6'h30, 32'h0003FFFE, 3'b000, 32'h0,        4'd4},
    '{1'b0, 2'd2, 6'h30, 32'h0,        3'b101, 32'h000301A0, 4'd4},  // R4 / R6
    '{1'b1, 2'd2, 6'h30, 32'h00010000, 3'b000, 32'h0,        4'd4},
    '{1'b0, 2'd2, 6'h30, 32'h0,        3'b010, 32'h00010140, 4'd6},  // R6 / R4
    '{1'b0, 2'd2, 6'h20, 32'h0,        3'b000, 32'hFFFFFFFF, 4'd10}, // R10 unmapped
    '{1'b0, 2'd1, 6'h2C, 32'h0,        3'b000, 32'hFFFFFFFF, 4'd10}, // R10 wrong size
    '{1'b0, 2'd0, 6'h34, 32'h0,        3'b000, 32'h0,        4'd7},  // R7 first take
    '{1'b0, 2'd0, 6'h34, 32'h0,        3'b000, 32'h1,        4'd7},  // R7 already taken
    '{1'b0, 2'd2, 6'h34, 32'h0,        3'b000, 32'hFFFFFFFF, 4'd10}  // R10 word read of semaphore
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    check("R1 warm", {31'b0, warm_rst_pulse}, 32'h0);
    check("R1 cold", {31'b0, cold_rst_pulse}, 32'h0);
    check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wd, VEC[i].irq, 4'h0, 1'b0);
      check($sformatf("R11 vec%0d rvalid", i), {31'b0, bus_rvalid}, {31'b0, !VEC[i].wr});
      if (!VEC[i].wr)
        check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp);
    end
    chan_irq = '0;

    // semaphore: word read did not change it, still taken
    access(1'b0, 2'd0, 6'h34, 0, 3'b0, 4'h0, 1'b0);
    check("R7 still taken", bus_rdata, 32'h1);
    idle(4'h0, 1'b1);
    access(1'b0, 2'd0, 6'h34, 0, 3'b0, 4'h0, 1'b0);
    check("R8 released", bus_rdata, 32'h0);
    access(1'b0, 2'd0, 6'h34, 0, 3'b0, 4'h0, 1'b1);
    check("R8 read with release returns old", bus_rdata, 32'h1);
    access(1'b0, 2'd0, 6'h34, 0, 3'b0, 4'h0, 1'b0);
    check("R8 release wins", bus_rdata, 32'h0);
    access(1'b1, 2'd0, 6'h34, 32'h0, 3'b0, 4'h0, 1'b0);
    access(1'b0, 2'd0, 6'h34, 0, 3'b0, 4'h0, 1'b0);
    check("R10 semaphore write ignored", bus_rdata, 32'h1);

    // reset pulses
    access(1'b1, 2'd2, 6'h2C, 32'h04, 3'b0, 4'h0, 1'b0);
    check("R3 warm pulse", {31'b0, warm_rst_pulse}, 32'h1);
    check("R3 no cold", {31'b0, cold_rst_pulse}, 32'h0);
    @(negedge clk);
    check("R3 warm one cycle", {31'b0, warm_rst_pulse}, 32'h0);
    access(1'b0, 2'd2, 6'h2C, 0, 3'b0, 4'h0, 1'b0);
    check("R3 control kept", bus_rdata, 32'h08);
    access(1'b1, 2'd2, 6'h2C, 32'h06, 3'b0, 4'h0, 1'b0);
    check("R3 warm both", {31'b0, warm_rst_pulse}, 32'h1);
    check("R3 cold both", {31'b0, cold_rst_pulse}, 32'h1);
    access(1'b1, 2'd0, 6'h2C, 32'h3F, 3'b0, 4'h0, 1'b0);
    check("R10 byte write no pulse", {30'b0, warm_rst_pulse, cold_rst_pulse}, 32'h0);
    access(1'b0, 2'd2, 6'h2C, 0, 3'b0, 4'h0, 1'b0);
    check("R10 byte write ignored", bus_rdata, 32'h08);

    // sticky status bits
    idle(4'hF, 1'b0);
    access(1'b0, 2'd2, 6'h30, 0, 3'b0, 4'h0, 1'b0);
    check("R5 sticky set", bus_rdata, 32'h00018D01);
    access(1'b1, 2'd2, 6'h30, 32'h00010401, 3'b0, 4'h0, 1'b0);
    access(1'b0, 2'd2, 6'h30, 0, 3'b0, 4'h0, 1'b0);
    check("R5 clear bits 10 and 0", bus_rdata, 32'h00018900);
    access(1'b1, 2'd2, 6'h30, 32'h00018000, 3'b0, 4'h8, 1'b0);
    access(1'b0, 2'd2, 6'h30, 0, 3'b0, 4'h0, 1'b0);
    check("R5 event beats clear", bus_rdata, 32'h00018900);
    access(1'b1, 2'd2, 6'h30, 32'h00018800, 3'b0, 4'h0, 1'b0);
    access(1'b0, 2'd2, 6'h30, 0, 3'b0, 4'h0, 1'b0);
    check("R5 clear bits 15 and 11", bus_rdata, 32'h00010100);

    // combined interrupt
    @(negedge clk); chan_irq = 3'b010;
    @(negedge clk);
    check("R9 irq set", {31'b0, irq_out}, 32'h1);
    chan_irq = 3'b000;
    @(negedge clk);
    check("R9 irq clear", {31'b0, irq_out}, 32'h0);
    chan_irq = 3'b100;
    @(negedge clk);
    check("R9 irq mic", {31'b0, irq_out}, 32'h1);
    chan_irq = 3'b000;

    // reset in mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    access(1'b0, 2'd2, 6'h2C, 0, 3'b0, 4'h0, 1'b0);
    check("R1 control after reset", bus_rdata, 32'h0);
    access(1'b0, 2'd2, 6'h30, 0, 3'b0, 4'h0, 1'b0);
    check("R1 status after reset", bus_rdata, 32'h100);
    access(1'b0, 2'd0, 6'h34, 0, 3'b0, 4'h0, 1'b0);
    check("R1 semaphore after reset", bus_rdata, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule